// File: doc/BRIEF.md
# Multi-Channel DMA Trigger Router

This block decides, cycle by cycle, which DMA channels are handed a service request. Each channel has a source-select byte that picks one of up to 64 peripheral request lines. A band of source numbers at the top of that range counts as permanently asserted. A channel can also be started by software writing its number. Other channels can start it too, either after each of their minor loops or when their major loop completes. The transfer engine and the arbitration between channels sit outside this block. The engine reports minor-loop ends, major completions, errors and a per-channel busy level. It receives a one-cycle trigger pulse per channel.

Software reaches the block through one write port. A write carries a kind code, a channel number and a data byte. The kinds are: configure the source select, start the channel, set the request enable, clear the request enable, and clear the error flag. Only peripheral requests that come through the source select are gated by the request-enable bit. Software starts and link starts always get through. A request that arrives while the channel is inside a minor loop is held in a one-bit pending flag. It is delivered once the engine drops busy.

Top module: `dma_trig_router`

## Requirements
- R1: After reset, all trigger pulses, request enables, error flags, pending flags and source-select bytes are zero.
- R2: A channel's source byte holds the source number in bits 5:0 and its enable in bit 7. While that enable and the channel's request enable are both set, a pulse on the selected `hw_req` line yields a one-cycle `trig` pulse on the next cycle. Pulses on other lines have no effect on that channel.
- R3: A write of kind 2 with a channel number sets that channel's request enable. Kind 3 clears it. While it is clear, peripheral requests do not trigger the channel. Other channels' enables are unchanged.
- R4: A source-byte write (kind 0) takes effect only if the new byte is zero or the channel's stored enable bit is clear. A nonzero write to an enabled channel is dropped, so reprogramming takes a zero write first.
- R5: Source numbers from `ALWAYS_FIRST` upward count as always asserted. An idle enabled channel selecting one of them triggers on every second cycle, and stops once its source byte is zeroed.
- R6: A write of kind 1 triggers the named channel once on the next cycle, whatever its request enable.
- R7: At a minor-loop end of channel s, its 16-bit iteration word is inspected. If bit 15 is set and the 9-bit count in bits 8:0 is greater than 1, the channel numbered in bits 12:9 is triggered. With count 1 (the final iteration) or bit 15 clear, nothing is triggered.
- R8: At a major completion of channel s, its 16-bit control word is inspected. If bit 5 is set, the channel numbered in bits 11:8 is triggered once.
- R9: A request reaching a channel while its `eng_busy` is high produces no trigger during busy. Exactly one trigger follows on the cycle after busy falls.
- R10: An `eng_err` pulse sets the channel's error flag. A write of kind 4 clears it. When a set and a clear coincide, the flag stays set.
- R11: Writes, and link targets, naming a channel number at or above `NUM_CH` affect no channel.
- R12: No channel's `trig` is high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe |
| wr_kind | input | 3 | 0 source byte, 1 start, 2 enable set, 3 enable clear, 4 error clear |
| wr_chan | input | 4 | Channel number addressed by the write |
| wr_data | input | 8 | Source byte for kind 0 |
| hw_req | input | NUM_SRC | Peripheral request pulses |
| eng_busy | input | NUM_CH | Channel is inside a minor loop |
| eng_minor_done | input | NUM_CH | Minor loop finished (one cycle) |
| eng_iter | input | NUM_CH*16 | Per-channel iteration word at minor end |
| eng_major_done | input | NUM_CH | Major loop finished (one cycle) |
| eng_ctrl | input | NUM_CH*16 | Per-channel control word |
| eng_err | input | NUM_CH | Transfer error pulse |
| trig | output | NUM_CH | Registered one-cycle trigger per channel |
| req_en | output | NUM_CH | Request-enable bits |
| err_flags | output | NUM_CH | Error flags |

## Verification
The bench builds the block with eight channels, 64 request sources and the always-asserted band starting at source 60. Eight channels leave the 4-bit channel fields able to name channels 8 to 15, so writes and link targets out of range can be driven directly. The top four source numbers let the continuous-trigger cadence be observed next to ordinary pulsed sources on another channel.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int CHN_W          = 4;
  localparam int WORD_W         = 16;
  localparam int MUX_W          = 8;
  localparam int MUX_EN_BIT     = 7;
  localparam int MUX_SRC_W      = 6;
  localparam int MINOR_LINK_BIT = 15;
  localparam int MINOR_TGT_LSB  = 9;
  localparam int MINOR_CNT_W    = 9;
  localparam int MAJOR_LINK_BIT = 5;
  localparam int MAJOR_TGT_LSB  = 8;

  typedef enum logic [2:0] {
    WK_MUX     = 3'd0,
    WK_START   = 3'd1,
    WK_EN_SET  = 3'd2,
    WK_EN_CLR  = 3'd3,
    WK_ERR_CLR = 3'd4
  } wr_kind_e;
endpackage

// File: rtl/dtr_cfg_regs.sv
module dtr_cfg_regs
  import dtr_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_valid,
  input  logic [2:0]               wr_kind,
  input  logic [CHN_W-1:0]         wr_chan,
  input  logic [MUX_W-1:0]         wr_data,
  input  logic [NUM_CH-1:0]        eng_err,
  output logic [NUM_CH*MUX_W-1:0]  mux_cfg,
  output logic [NUM_CH-1:0]        req_en,
  output logic [NUM_CH-1:0]        err_flags,
  output logic [NUM_CH-1:0]        sw_start
);
  wr_kind_e          kind;
  logic              chan_ok;
  logic [NUM_CH-1:0] hit;

  assign kind    = wr_kind_e'(wr_kind);
  assign chan_ok = ({1'b0, wr_chan} < (CHN_W+1)'(NUM_CH));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [MUX_W-1:0] mux_q;
    logic             en_q;
    logic             err_q;
    logic             mux_take;

    assign hit[c]    = wr_valid & chan_ok & (wr_chan == CHN_W'(c));
    assign mux_take  = hit[c] && (kind == WK_MUX) &&
                       ((wr_data == '0) || !mux_q[MUX_EN_BIT]);
    assign sw_start[c] = hit[c] && (kind == WK_START);

    always_ff @(posedge clk) begin
      if (rst) begin
        mux_q <= '0;
        en_q  <= 1'b0;
        err_q <= 1'b0;
      end else begin
        if (mux_take)
          mux_q <= wr_data;
        if (hit[c] && kind == WK_EN_SET)
          en_q <= 1'b1;
        else if (hit[c] && kind == WK_EN_CLR)
          en_q <= 1'b0;
        err_q <= (err_q & ~(hit[c] && kind == WK_ERR_CLR)) | eng_err[c];
      end
    end

    assign mux_cfg[c*MUX_W +: MUX_W] = mux_q;
    assign req_en[c]    = en_q;
    assign err_flags[c] = err_q;
  end
endmodule

// File: rtl/dtr_src_sel.sv
module dtr_src_sel
  import dtr_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int NUM_SRC      = 64,
  parameter int ALWAYS_FIRST = 60
) (
  input  logic [NUM_CH*MUX_W-1:0] mux_cfg,
  input  logic [NUM_CH-1:0]       req_en,
  input  logic [NUM_SRC-1:0]      hw_req,
  output logic [NUM_CH-1:0]       hw_hit
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [MUX_SRC_W-1:0] src;
    logic                 sel_en;
    logic                 level;

    assign src    = mux_cfg[c*MUX_W +: MUX_SRC_W];
    assign sel_en = mux_cfg[c*MUX_W + MUX_EN_BIT];

    always_comb begin
      level = 1'b0;
      if (int'(src) >= ALWAYS_FIRST)
        level = 1'b1;
      else if (int'(src) < NUM_SRC)
        level = hw_req[src];
    end

    assign hw_hit[c] = sel_en & req_en[c] & level;
  end
endmodule

// File: rtl/dtr_link_dec.sv
module dtr_link_dec
  import dtr_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0]        minor_done,
  input  logic [NUM_CH*WORD_W-1:0] iter_words,
  input  logic [NUM_CH-1:0]        major_done,
  input  logic [NUM_CH*WORD_W-1:0] ctrl_words,
  output logic [NUM_CH-1:0]        link_req
);
  always_comb begin
    logic [WORD_W-1:0] w_min;
    logic [WORD_W-1:0] w_maj;
    link_req = '0;
    w_min    = '0;
    w_maj    = '0;
    for (int s = 0; s < NUM_CH; s++) begin
      w_min = iter_words[s*WORD_W +: WORD_W];
      w_maj = ctrl_words[s*WORD_W +: WORD_W];
      if (minor_done[s] && w_min[MINOR_LINK_BIT] &&
          (w_min[MINOR_CNT_W-1:0] > MINOR_CNT_W'(1)))
        link_req = link_req |
                   (NUM_CH'(1) << w_min[MINOR_TGT_LSB +: CHN_W]);
      if (major_done[s] && w_maj[MAJOR_LINK_BIT])
        link_req = link_req |
                   (NUM_CH'(1) << w_maj[MAJOR_TGT_LSB +: CHN_W]);
    end
  end
endmodule

// File: rtl/dtr_chan_seq.sv
module dtr_chan_seq #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] busy,
  output logic [NUM_CH-1:0] trig
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic pend_q;
    logic trig_q;
    logic fire;
    logic trig_d;

    assign fire   = req[c] | pend_q;
    assign trig_d = fire & ~busy[c] & ~trig_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
        trig_q <= 1'b0;
      end else begin
        trig_q <= trig_d;
        pend_q <= fire & ~trig_d;
      end
    end

    assign trig[c] = trig_q;
  end
endmodule

// File: rtl/dma_trig_router.sv
module dma_trig_router
  import dtr_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int NUM_SRC      = 64,
  parameter int ALWAYS_FIRST = 60
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_valid,
  input  logic [2:0]               wr_kind,
  input  logic [3:0]               wr_chan,
  input  logic [7:0]               wr_data,
  input  logic [NUM_SRC-1:0]       hw_req,
  input  logic [NUM_CH-1:0]        eng_busy,
  input  logic [NUM_CH-1:0]        eng_minor_done,
  input  logic [NUM_CH*16-1:0]     eng_iter,
  input  logic [NUM_CH-1:0]        eng_major_done,
  input  logic [NUM_CH*16-1:0]     eng_ctrl,
  input  logic [NUM_CH-1:0]        eng_err,
  output logic [NUM_CH-1:0]        trig,
  output logic [NUM_CH-1:0]        req_en,
  output logic [NUM_CH-1:0]        err_flags
);
  logic [NUM_CH*MUX_W-1:0] mux_cfg;
  logic [NUM_CH-1:0]       sw_start;
  logic [NUM_CH-1:0]       hw_hit;
  logic [NUM_CH-1:0]       link_req;
  logic [NUM_CH-1:0]       any_req;

  dtr_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_kind  (wr_kind),
    .wr_chan  (wr_chan),
    .wr_data  (wr_data),
    .eng_err  (eng_err),
    .mux_cfg  (mux_cfg),
    .req_en   (req_en),
    .err_flags(err_flags),
    .sw_start (sw_start)
  );

  dtr_src_sel #(
    .NUM_CH      (NUM_CH),
    .NUM_SRC     (NUM_SRC),
    .ALWAYS_FIRST(ALWAYS_FIRST)
  ) u_sel (
    .mux_cfg(mux_cfg),
    .req_en (req_en),
    .hw_req (hw_req),
    .hw_hit (hw_hit)
  );

  dtr_link_dec #(.NUM_CH(NUM_CH)) u_link (
    .minor_done(eng_minor_done),
    .iter_words(eng_iter),
    .major_done(eng_major_done),
    .ctrl_words(eng_ctrl),
    .link_req  (link_req)
  );

  assign any_req = hw_hit | sw_start | link_req;

  dtr_chan_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk (clk),
    .rst (rst),
    .req (any_req),
    .busy(eng_busy),
    .trig(trig)
  );
endmodule

// File: rtl/dtr_checker.sv
module dtr_checker #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [2:0]        wr_kind,
  input logic [3:0]        wr_chan,
  input logic [NUM_CH-1:0] eng_busy,
  input logic [NUM_CH-1:0] eng_err,
  input logic [NUM_CH-1:0] trig,
  input logic [NUM_CH-1:0] req_en,
  input logic [NUM_CH-1:0] err_flags
);
  logic [NUM_CH-1:0] start_vec;
  logic [NUM_CH-1:0] clr_vec;
  logic              bad_chan;

  assign start_vec = (wr_valid && wr_kind == 3'd1) ? (NUM_CH'(1) << wr_chan) : '0;
  assign clr_vec   = (wr_valid && wr_kind == 3'd3) ? (NUM_CH'(1) << wr_chan) : '0;
  assign bad_chan  = wr_valid && ({1'b0, wr_chan} >= 5'(NUM_CH));

  AST_TRIG_SPACING: assert property (@(posedge clk) disable iff (rst)
    (trig != '0) |=> ((trig & $past(trig)) == '0)); // R12

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (eng_busy != '0) |=> ((trig & $past(eng_busy)) == '0)); // R9

  AST_SW_START: assert property (@(posedge clk) disable iff (rst)
    ((start_vec & ~eng_busy & ~trig) != '0) |=> ((trig & $past(start_vec)) != '0)); // R6

  AST_EN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_vec != '0) |=> ((req_en & $past(clr_vec)) == '0)); // R3

  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (eng_err != '0) |=> ((err_flags & $past(eng_err)) == $past(eng_err))); // R10

  AST_BAD_CHAN: assert property (@(posedge clk) disable iff (rst)
    bad_chan |=> $stable(req_en)); // R11
endmodule

bind dma_trig_router dtr_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .wr_kind  (wr_kind),
  .wr_chan  (wr_chan),
  .eng_busy (eng_busy),
  .eng_err  (eng_err),
  .trig     (trig),
  .req_en   (req_en),
  .err_flags(err_flags)
);

// File: tb/sim_dma_trig_router.sv
module sim_dma_trig_router;
  localparam int NCH  = 8;
  localparam int NSRC = 64;
  localparam int AF   = 60;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_valid = 1'b0;
  logic [2:0]        wr_kind = '0;
  logic [3:0]        wr_chan = '0;
  logic [7:0]        wr_data = '0;
  logic [NSRC-1:0]   hw_req = '0;
  logic [NCH-1:0]    eng_busy = '0;
  logic [NCH-1:0]    eng_minor_done = '0;
  logic [NCH*16-1:0] eng_iter = '0;
  logic [NCH-1:0]    eng_major_done = '0;
  logic [NCH*16-1:0] eng_ctrl = '0;
  logic [NCH-1:0]    eng_err = '0;
  logic [NCH-1:0]    trig;
  logic [NCH-1:0]    req_en;
  logic [NCH-1:0]    err_flags;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dma_trig_router #(.NUM_CH(NCH), .NUM_SRC(NSRC), .ALWAYS_FIRST(AF)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_kind(wr_kind),
    .wr_chan(wr_chan), .wr_data(wr_data), .hw_req(hw_req),
    .eng_busy(eng_busy), .eng_minor_done(eng_minor_done), .eng_iter(eng_iter),
    .eng_major_done(eng_major_done), .eng_ctrl(eng_ctrl), .eng_err(eng_err),
    .trig(trig), .req_en(req_en), .err_flags(err_flags)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] k, logic [3:0] ch, logic [7:0] d);
    wr_valid = 1'b1; wr_kind = k; wr_chan = ch; wr_data = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic pulse_src(int s);
    hw_req[s] = 1'b1;
    step();
    hw_req = '0;
  endtask

  task automatic t_reset();
    chk("R1 trig", 32'(trig), 32'h0);
    chk("R1 req_en", 32'(req_en), 32'h0);
    chk("R1 err_flags", 32'(err_flags), 32'h0);
  endtask

  task automatic t_hw();
    wr(3'd0, 4'd2, 8'h85);
    wr(3'd2, 4'd2, 8'h00);
    chk("R3 enable set", 32'(req_en), 32'h04);
    pulse_src(5);
    chk("R2 selected source", 32'(trig), 32'h04);
    step();
    chk("R2 single pulse", 32'(trig), 32'h0);
    pulse_src(6);
    chk("R2 other source", 32'(trig), 32'h0);
  endtask

  task automatic t_gate();
    wr(3'd3, 4'd2, 8'h00);
    chk("R3 enable clear", 32'(req_en), 32'h0);
    pulse_src(5);
    chk("R3 gated", 32'(trig), 32'h0);
    wr(3'd2, 4'd2, 8'h00);
  endtask

  task automatic t_remux();
    wr(3'd0, 4'd2, 8'h87);
    pulse_src(7);
    chk("R4 dropped write, new src", 32'(trig), 32'h0);
    pulse_src(5);
    chk("R4 dropped write, old src", 32'(trig), 32'h04);
    wr(3'd0, 4'd2, 8'h00);
    wr(3'd0, 4'd2, 8'h87);
    pulse_src(7);
    chk("R4 reprogrammed", 32'(trig), 32'h04);
    step();
  endtask

  task automatic t_always();
    int cnt = 0;
    int back2back = 0;
    logic prev = 1'b0;
    wr(3'd0, 4'd4, 8'h80 | 8'(61));
    wr(3'd2, 4'd4, 8'h00);
    for (int i = 0; i < 8; i++) begin
      step();
      if (trig[4]) cnt++;
      if (trig[4] && prev) back2back++;
      prev = trig[4];
    end
    chk("R5 continuous count", 32'(cnt), 32'd4);
    chk("R12 no back-to-back", 32'(back2back), 32'd0);
    wr(3'd0, 4'd4, 8'h00);
    wr(3'd3, 4'd4, 8'h00);
    step();
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R5 stopped", 32'(trig), 32'h0);
    end
  endtask

  task automatic t_swstart();
    wr(3'd1, 4'd0, 8'h00);
    chk("R6 start without enable", 32'(trig), 32'h01);
    step();
    chk("R6 one pulse", 32'(trig), 32'h0);
  endtask

  task automatic minor(logic [15:0] w);
    eng_iter[16 +: 16] = w;
    eng_minor_done[1]  = 1'b1;
    step();
    eng_minor_done = '0;
  endtask

  task automatic t_minor();
    minor(16'h8605);
    chk("R7 minor link fires", 32'(trig), 32'h08);
    step();
    minor(16'h8601);
    chk("R7 final iteration", 32'(trig), 32'h0);
    minor(16'h0605);
    chk("R7 link off", 32'(trig), 32'h0);
  endtask

  task automatic major(logic [15:0] w);
    eng_ctrl[16 +: 16] = w;
    eng_major_done[1]  = 1'b1;
    step();
    eng_major_done = '0;
  endtask

  task automatic t_major();
    major(16'h0620);
    chk("R8 major link fires", 32'(trig), 32'h40);
    step();
    chk("R8 once", 32'(trig), 32'h0);
    major(16'h0600);
    chk("R8 link off", 32'(trig), 32'h0);
  endtask

  task automatic t_pending();
    eng_busy[5] = 1'b1;
    wr(3'd1, 4'd5, 8'h00);
    chk("R9 held while busy", 32'(trig), 32'h0);
    step();
    chk("R9 still held", 32'(trig), 32'h0);
    eng_busy[5] = 1'b0;
    step();
    chk("R9 delivered", 32'(trig), 32'h20);
    step();
    chk("R9 single delivery", 32'(trig), 32'h0);
  endtask

  task automatic t_err();
    eng_err[3] = 1'b1;
    step();
    eng_err = '0;
    chk("R10 error set", 32'(err_flags), 32'h08);
    wr(3'd4, 4'd3, 8'h00);
    chk("R10 error cleared", 32'(err_flags), 32'h0);
    eng_err[3] = 1'b1;
    wr(3'd4, 4'd3, 8'h00);
    eng_err = '0;
    chk("R10 set wins", 32'(err_flags), 32'h08);
    wr(3'd4, 4'd3, 8'h00);
    chk("R10 final clear", 32'(err_flags), 32'h0);
  endtask

  task automatic t_range();
    wr(3'd1, 4'd9, 8'h00);
    chk("R11 start out of range", 32'(trig), 32'h0);
    wr(3'd2, 4'd10, 8'h00);
    chk("R11 enable out of range", 32'(req_en), 32'h04);
    minor(16'h9805);
    chk("R11 link target out of range", 32'(trig), 32'h0);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_hw();
    t_gate();
    t_remux();
    t_always();
    t_swstart();
    t_minor();
    t_major();
    t_pending();
    t_err();
    t_range();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule